// File: doc/BRIEF.md
# Disk Sector Data-Transfer Sequencer

This block is the drive-side sequencer for the synchronous data section of a disk peripheral bus. After a data-transfer command has been accepted and the controller holds the run line high, the sequencer marks the data bus busy and produces a sync clock, one pulse per word. On a read it places each word, taken from a show-ahead sector buffer port, on the bus together with an odd parity bit. On a write it captures the word the controller presents when the controller's echo of the sync clock (the write clock) rises, and checks its parity.

Each sector ends with an end-of-block pulse of fixed width. The run line is sampled in the last cycle of that pulse, which decides whether another sector follows or the bus is released. An error condition (a received parity mismatch or a drive fault) raises the exception line, which stays up until end-of-block falls. A drive fault also cuts the sector short: the end-of-block pulse starts at once and the transfer ends after it, whatever the run line says.

Top module: `sector_xfer_seq`

## Requirements
- R1: The read data output and its parity bit together always hold an odd number of ones (`bus_par_o` = NOT XOR of `bus_data_o`).
- R2: On a read, `rd_req_o` pulses once per word, the word on `rd_word_i` in that cycle appears on `bus_data_o` in the cycle `sclk_o` rises, and `bus_data_o` changes at no other time.
- R3: On a write, the bus word is captured at the first clock edge at which `wclk_i` is seen high after being low, and is presented on `wr_word_o` with a one-cycle `wr_valid_o` pulse in the next cycle.
- R4: A captured write word whose 19 bits hold an even number of ones sets the sticky `par_err_o`; it is cleared only when a new command (`start_i` while idle) is accepted.
- R5: `occ_o` rises one cycle after a pending or arriving command meets `run_i` high; a command with `run_i` low leaves `occ_o` low until `run_i` rises.
- R6: Each sector has exactly SECTOR_WORDS `sclk_o` pulses, each SCLK_HI cycles high and SCLK_LO cycles low, followed by `ebl_o` high for EBL_CYC cycles; `sclk_o` is low whenever `ebl_o` is high.
- R7: `run_i` is sampled in the last `ebl_o` cycle: high starts the next sector with `occ_o` held high, low ends the transfer with `occ_o` falling in the same cycle as `ebl_o`.
- R8: `exc_o` rises no later than `ebl_o` when an error occurs in a sector and falls in the same cycle as `ebl_o`.
- R9: `fault_i` high during a sector starts `ebl_o` in the next cycle with no further `sclk_o` pulse, raises `exc_o`, and ends the transfer after that end-of-block even with `run_i` high.
- R10: Out of reset `occ_o`, `ebl_o`, `exc_o`, `sclk_o`, `par_err_o` and `wr_valid_o` are low.
- R11: `start_i` while `occ_o` is high is ignored: no transfer follows once the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse: a valid data-transfer command was written |
| write_i | input | 1 | Direction of the command, 1 = write, 0 = read; sampled with `start_i` |
| run_i | input | 1 | Run line from the controller |
| fault_i | input | 1 | Drive fault requesting an early end of sector |
| wclk_i | input | 1 | Write clock echoed by the controller |
| bus_data_i | input | WORD_W | Write data from the bus |
| bus_par_i | input | 1 | Write parity bit from the bus |
| rd_word_i | input | WORD_W | Next read word from the sector buffer (show-ahead) |
| rd_req_o | output | 1 | Pops one read word from the sector buffer |
| bus_data_o | output | WORD_W | Read data to the bus |
| bus_par_o | output | 1 | Read parity bit to the bus |
| bus_oe_o | output | 1 | Drive enable for the read data lines |
| wr_word_o | output | WORD_W | Captured write word |
| wr_valid_o | output | 1 | Captured write word is valid |
| par_err_o | output | 1 | Sticky write parity error |
| occ_o | output | 1 | Data bus occupied |
| ebl_o | output | 1 | End-of-block pulse |
| exc_o | output | 1 | Exception during the transfer |
| sclk_o | output | 1 | Sync clock to the controller |

## Verification
The assertions watch, on every cycle, the invariants of the line relationships: odd parity on the read lines, read data moving only on a sync clock rise, no sync clock during end-of-block, busy dropping only together with end-of-block, exception dropping by the end of end-of-block, single-cycle write strobes and the stickiness of the parity flag. Only the bench scenarios show the counted behaviour: the number and shape of pulses per sector, the end-of-block width, the per-sector continue-or-stop decision on the run line, the order of words read and captured, the shortened sector after a fault and the ignored command while busy.

// File: rtl/sxs_pkg.sv
package sxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_EBL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sxs_sclk_gen.sv
module sxs_sclk_gen #(
  parameter int SECTOR_WORDS = 256,
  parameter int SCLK_HI      = 2,
  parameter int SCLK_LO      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic word_start_o,
  output logic sector_end_o
);
  localparam int PER  = SCLK_HI + SCLK_LO;
  localparam int PH_W = (PER > 2) ? $clog2(PER) : 1;
  localparam int WC_W = $clog2(SECTOR_WORDS + 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PER - 1);
  localparam logic [PH_W-1:0] PH_HI   = PH_W'(SCLK_HI);
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(SECTOR_WORDS - 1);

  logic [PH_W-1:0] ph_q;
  logic [WC_W-1:0] wcnt_q;
  logic            sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      wcnt_q <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      ph_q   <= '0;
      wcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      sclk_q <= (ph_q < PH_HI);
      if (ph_q == PH_LAST) begin
        ph_q   <= '0;
        wcnt_q <= wcnt_q + 1'b1;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign sclk_o       = sclk_q;
  assign word_start_o = en_i && (ph_q == '0);
  assign sector_end_o = en_i && (ph_q == PH_LAST) && (wcnt_q == WC_LAST);
endmodule

// File: rtl/sxs_rd_drive.sv
module sxs_rd_drive #(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] data_o,
  output logic              par_o
);
  logic [WORD_W-1:0] data_q;
  logic              par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      par_q  <= 1'b1;
    end else if (load_i) begin
      data_q <= word_i;
      par_q  <= ~(^word_i);
    end
  end

  assign data_o = data_q;
  assign par_o  = par_q;

  p_odd_parity_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (^{data_o, par_o}) == 1'b1)
    else $error("R1 read word parity not odd");
endmodule

// File: rtl/sxs_wr_capture.sv
module sxs_wr_capture #(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              clr_i,
  input  logic              wclk_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              par_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              perr_pulse_o,
  output logic              perr_o
);
  logic              wclk_q;
  logic [WORD_W-1:0] word_q;
  logic              valid_q;
  logic              perr_pulse_q;
  logic              perr_q;
  logic              rise;
  logic              bad;

  assign rise = arm_i && wclk_i && !wclk_q;
  assign bad  = ~(^{data_i, par_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q       <= 1'b0;
      word_q       <= '0;
      valid_q      <= 1'b0;
      perr_pulse_q <= 1'b0;
      perr_q       <= 1'b0;
    end else begin
      wclk_q       <= wclk_i;
      valid_q      <= rise;
      perr_pulse_q <= rise && bad;
      if (rise) word_q <= data_i;
      if (clr_i)             perr_q <= 1'b0;
      else if (rise && bad)  perr_q <= 1'b1;
    end
  end

  assign word_o       = word_q;
  assign valid_o      = valid_q;
  assign perr_pulse_o = perr_pulse_q;
  assign perr_o       = perr_q;

  p_valid_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o)
    else $error("R3 write strobe longer than one cycle");

  p_perr_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perr_o && !clr_i) |=> perr_o)
    else $error("R4 parity flag lost without clear");
endmodule

// File: rtl/sector_xfer_seq.sv
module sector_xfer_seq
  import sxs_pkg::*;
#(
  parameter int WORD_W       = 18,
  parameter int SECTOR_WORDS = 256,
  parameter int SCLK_HI      = 2,
  parameter int SCLK_LO      = 2,
  parameter int EBL_CYC      = 500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              write_i,
  input  logic              run_i,
  input  logic              fault_i,
  input  logic              wclk_i,
  input  logic [WORD_W-1:0] bus_data_i,
  input  logic              bus_par_i,
  input  logic [WORD_W-1:0] rd_word_i,
  output logic              rd_req_o,
  output logic [WORD_W-1:0] bus_data_o,
  output logic              bus_par_o,
  output logic              bus_oe_o,
  output logic [WORD_W-1:0] wr_word_o,
  output logic              wr_valid_o,
  output logic              par_err_o,
  output logic              occ_o,
  output logic              ebl_o,
  output logic              exc_o,
  output logic              sclk_o
);
  localparam int EC_W = $clog2(EBL_CYC + 1);
  localparam logic [EC_W-1:0] EC_LAST = EC_W'(EBL_CYC - 1);

  seq_state_e      state_q;
  logic [EC_W-1:0] ebl_cnt_q;
  logic            cmd_pend_q;
  logic            dir_wr_q;
  logic            abort_q;
  logic            exc_q;

  logic in_idle, in_xfer, in_ebl;
  logic go, ebl_last, clr_cmd;
  logic sclk_en, word_start, sector_end;
  logic perr_pulse;

  assign in_idle  = (state_q == ST_IDLE);
  assign in_xfer  = (state_q == ST_XFER);
  assign in_ebl   = (state_q == ST_EBL);
  assign go       = in_idle && (cmd_pend_q || start_i) && run_i;
  assign ebl_last = in_ebl && (ebl_cnt_q == EC_LAST);
  assign clr_cmd  = in_idle && start_i;
  assign sclk_en  = in_xfer && !fault_i;

  sxs_sclk_gen #(
    .SECTOR_WORDS(SECTOR_WORDS),
    .SCLK_HI     (SCLK_HI),
    .SCLK_LO     (SCLK_LO)
  ) u_sclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (sclk_en),
    .sclk_o      (sclk_o),
    .word_start_o(word_start),
    .sector_end_o(sector_end)
  );

  assign rd_req_o = word_start && !dir_wr_q;

  sxs_rd_drive #(.WORD_W(WORD_W)) u_rd (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(rd_req_o),
    .word_i(rd_word_i),
    .data_o(bus_data_o),
    .par_o (bus_par_o)
  );

  sxs_wr_capture #(.WORD_W(WORD_W)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (in_xfer && dir_wr_q),
    .clr_i       (clr_cmd),
    .wclk_i      (wclk_i),
    .data_i      (bus_data_i),
    .par_i       (bus_par_i),
    .word_o      (wr_word_o),
    .valid_o     (wr_valid_o),
    .perr_pulse_o(perr_pulse),
    .perr_o      (par_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      ebl_cnt_q  <= '0;
      cmd_pend_q <= 1'b0;
      dir_wr_q   <= 1'b0;
      abort_q    <= 1'b0;
      exc_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) dir_wr_q <= write_i;
          if (go) begin
            state_q    <= ST_XFER;
            cmd_pend_q <= 1'b0;
          end else if (start_i) begin
            cmd_pend_q <= 1'b1;
          end
        end
        ST_XFER: begin
          if (fault_i) begin
            state_q <= ST_EBL;
            abort_q <= 1'b1;
            exc_q   <= 1'b1;
          end else begin
            if (sector_end) state_q <= ST_EBL;
            if (perr_pulse) exc_q <= 1'b1;
          end
        end
        ST_EBL: begin
          if (ebl_last) begin
            ebl_cnt_q <= '0;
            exc_q     <= 1'b0;
            abort_q   <= 1'b0;
            state_q   <= (run_i && !abort_q) ? ST_XFER : ST_IDLE;
          end else begin
            ebl_cnt_q <= ebl_cnt_q + 1'b1;
            if (perr_pulse) exc_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign occ_o    = !in_idle;
  assign ebl_o    = in_ebl;
  assign exc_o    = exc_q;
  assign bus_oe_o = !in_idle && !dir_wr_q;

  p_no_sclk_in_ebl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> (occ_o && !ebl_o))
    else $error("R6 sync clock outside data phase");

  p_occ_with_ebl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(occ_o) |-> $fell(ebl_o))
    else $error("R7 busy dropped apart from end-of-block");

  p_exc_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ebl_o) |-> !exc_o)
    else $error("R8 exception outlives end-of-block");

  p_rd_data_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sclk_o) |-> $stable(bus_data_o))
    else $error("R2 read data moved off a sync clock rise");

  p_fault_cut_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_xfer && fault_i) |=> (ebl_o && exc_o && !sclk_o))
    else $error("R9 fault did not cut the sector");
endmodule

// File: tb/sim_sector_xfer_seq.sv
module sim_sector_xfer_seq;
  localparam int W   = 18;
  localparam int NW  = 8;
  localparam int HI  = 2;
  localparam int LO  = 2;
  localparam int EBC = 6;

  // {corrupt_parity, data}
  localparam logic [W:0] WVEC [NW] = '{
    {1'b0, 18'h00000}, {1'b0, 18'h3FFFF}, {1'b0, 18'h15555}, {1'b1, 18'h2AAAA},
    {1'b0, 18'h00001}, {1'b0, 18'h20000}, {1'b0, 18'h1234F}, {1'b0, 18'h3C3C3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wr_dir = 1'b0, run = 1'b0, fault = 1'b0;
  logic echo_en = 1'b0;
  logic wclk;
  logic [W-1:0] bdata_in = '0;
  logic bpar_in = 1'b1;
  logic [W-1:0] rd_word;
  logic rd_req, bpar_out, boe, wr_valid, perr, occ, ebl, exc, sclk;
  logic [W-1:0] bdata_out, wr_word;

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  int src_cnt = 0, rd_k = 0, rd_bad = 0;
  int sclk_rises = 0, base_rises = 0, last_pulses = 0;
  int hi_len = 0, lo_len = 0, width_bad = 0;
  int ebl_len = 0, last_ebl_len = 0, ebl_count = 0;
  int occ_fall_bad = 0, exc_fall_bad = 0, exc_in_ebl = 0, sclk_in_ebl = 0;
  int cap_k = 0;
  logic [W-1:0] cap_word [NW];
  logic rdreq_prev = 1'b0, sclk_prev = 1'b0, ebl_prev = 1'b0, occ_prev = 1'b0, exc_prev = 1'b0;
  logic rd_mode = 1'b0;
  bit done = 1'b0;

  function automatic logic [W-1:0] pat(input int n);
    return W'(18'h2A5A5 ^ (n * 18'h01357));
  endfunction

  assign rd_word = pat(src_cnt);
  assign wclk    = echo_en & sclk;

  sector_xfer_seq #(
    .WORD_W(W), .SECTOR_WORDS(NW), .SCLK_HI(HI), .SCLK_LO(LO), .EBL_CYC(EBC)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr_dir), .run_i(run),
    .fault_i(fault), .wclk_i(wclk), .bus_data_i(bdata_in), .bus_par_i(bpar_in),
    .rd_word_i(rd_word), .rd_req_o(rd_req), .bus_data_o(bdata_out), .bus_par_o(bpar_out),
    .bus_oe_o(boe), .wr_word_o(wr_word), .wr_valid_o(wr_valid), .par_err_o(perr),
    .occ_o(occ), .ebl_o(ebl), .exc_o(exc), .sclk_o(sclk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rdreq_prev) src_cnt++;
    rdreq_prev = rd_req;
    if (sclk && !sclk_prev) begin
      sclk_rises++;
      if (rd_mode) begin
        if (bdata_out !== pat(rd_k) || (^{bdata_out, bpar_out}) !== 1'b1) rd_bad++;
        rd_k++;
      end
      if (sclk_rises > base_rises + 1 && lo_len != LO) width_bad++;
      hi_len = 0;
    end
    if (sclk) hi_len++;
    if (!sclk && sclk_prev) begin
      if (hi_len != HI) width_bad++;
      lo_len = 0;
    end
    if (!sclk) lo_len++;
    if (ebl && !ebl_prev) begin
      last_pulses = sclk_rises - base_rises;
      ebl_len = 0;
    end
    if (ebl) begin
      ebl_len++;
      if (exc) exc_in_ebl++;
      if (sclk) sclk_in_ebl++;
    end
    if (!ebl && ebl_prev) begin
      last_ebl_len = ebl_len;
      ebl_count++;
      base_rises = sclk_rises;
    end
    if (occ_prev && !occ && !(ebl_prev && !ebl)) occ_fall_bad++;
    if (exc_prev && !exc && !(ebl_prev && !ebl)) exc_fall_bad++;
    if (wr_valid && cap_k < NW) begin
      cap_word[cap_k] = wr_word;
      cap_k++;
    end
    sclk_prev = sclk; ebl_prev = ebl; occ_prev = occ; exc_prev = exc;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic dir);
    @(negedge clk);
    start = 1'b1; wr_dir = dir;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (occ) @(negedge clk);
    cyc(2);
  endtask

  task automatic drive_w(input int i);
    bdata_in = WVEC[i][W-1:0];
    bpar_in  = (~(^WVEC[i][W-1:0])) ^ WVEC[i][W];
  endtask

  initial begin
    cyc(3);
    // R10 reset state
    chk("R10 occ", occ, 0); chk("R10 ebl", ebl, 0); chk("R10 exc", exc, 0);
    chk("R10 sclk", sclk, 0); chk("R10 par_err", perr, 0); chk("R10 wr_valid", wr_valid, 0);
    rst_n = 1'b1;
    cyc(2);

    // R5: command with run low waits
    rd_mode = 1'b1;
    issue(1'b0);
    cyc(4);
    chk("R5 occ low without run", occ, 0);
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R5 occ after run", occ, 1);
    // R11: command while busy is ignored
    start = 1'b1; wr_dir = 1'b1;
    @(negedge clk);
    start = 1'b0; wr_dir = 1'b0;
    // R7: run high keeps the transfer going into sector two
    @(negedge clk);
    while (ebl_count < 1) @(negedge clk);
    chk("R7 occ held across sectors", occ, 1);
    chk("R6 pulses sector 1", last_pulses, NW);
    chk("R6 ebl width", last_ebl_len, EBC);
    run = 1'b0;
    wait_idle();
    chk("R7 two sectors", ebl_count, 2);
    chk("R6 pulses sector 2", last_pulses, NW);
    chk("R6 sclk widths", width_bad, 0);
    chk("R6 no sclk in ebl", sclk_in_ebl, 0);
    chk("R7 occ falls with ebl", occ_fall_bad, 0);
    chk("R2 read words seen", rd_k, 2 * NW);
    chk("R2 R1 read data and parity", rd_bad, 0);
    chk("R2 words popped", src_cnt, 2 * NW);
    chk("R8 no exc on clean read", exc_in_ebl, 0);
    run = 1'b1;
    cyc(6);
    chk("R11 ignored command", occ, 0);
    run = 1'b0;
    rd_mode = 1'b0;

    // R3 R4 R8 write sector walked from the vector table
    echo_en = 1'b1;
    drive_w(0);
    issue(1'b1);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < NW; i++) begin
      drive_w(i);
      while (!sclk) @(negedge clk);
      while (sclk) @(negedge clk);
    end
    wait_idle();
    echo_en = 1'b0;
    chk("R3 words captured", cap_k, NW);
    for (int i = 0; i < NW; i++)
      chk($sformatf("R3 word %0d", i), cap_word[i], WVEC[i][W-1:0]);
    chk("R4 sticky parity error", perr, 1);
    chk("R8 exc during ebl", exc_in_ebl > 0, 1);
    chk("R8 exc falls with ebl", exc_fall_bad, 0);
    chk("R7 single write sector", ebl_count, 3);

    // R9 fault ends the sector early and the transfer
    rd_mode = 1'b1; rd_k = 0; src_cnt = 0;
    exc_in_ebl = 0;
    issue(1'b0);
    chk("R4 clear on new command", perr, 0);
    run = 1'b1;
    @(negedge clk);
    while (sclk_rises - base_rises < 3) @(negedge clk);
    fault = 1'b1;
    @(negedge clk);
    fault = 1'b0;
    chk("R9 ebl next cycle", ebl, 1);
    chk("R9 exc raised", exc, 1);
    cyc(EBC + 4);
    chk("R9 short sector", last_pulses, 3);
    chk("R9 ends despite run", occ, 0);
    chk("R8 exc falls with ebl", exc_fall_bad, 0);
    chk("R7 occ falls with ebl", occ_fall_bad, 0);
    run = 1'b0;
    cyc(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule